// File: doc/BRIEF.md
# Segment Address Extension and Protection Unit

This block sits between a processor's data port and external memory. Every request carries a 32-bit logical address and an access type. The block compares the address with a table of sixteen programmable segments. Each segment holds a logical base, a physical base, a power-of-two size code and separate read, write and execute enables.

When an enabled segment matches and allows the access, the block forwards the request one cycle later. The forwarded address is 36 bits wide: the address bits above the segment size come from the physical base, and the bits below it come from the logical address. A request that no segment matches, or that the winning segment does not allow, is not forwarded. Instead the block raises a one-cycle deny pulse.

The first denied access is recorded in a fault address register and a fault status register. They keep that record until a clear pulse arrives. Matching ignores every base bit below the segment size, so a base that is not aligned to its size covers the aligned block that contains it, not the range the programmer intended. Regions that are not a power of two in size are built by placing several entries side by side.

Top module: `seg_xlate_prot`

## Requirements
- R1: While `rst` is high at a clock edge, `mem_valid`, `deny` and `flt_valid` are 0 after that edge, and every segment entry is reset to size code 0.
- R2: A request sampled with `req_valid` high at edge N produces exactly one of `mem_valid` or `deny` after edge N+1. With `req_valid` low, neither is produced.
- R3: For a granted request, `mem_addr` equals the 36-bit physical base with its bits below the segment size cleared, ORed with the logical address bits below the segment size.
- R4: Size code s from 1 to 21 selects a segment of 2^(s+11) bytes (s=10 gives 2 MB, s=11 gives 4 MB). Codes above 21 select the whole 4 GB space. Code 0 disables the entry, and it never matches.
- R5: Bits of the logical or physical base below the segment size are ignored. An unaligned entry covers the aligned block that contains its base, and addresses outside that block do not hit it.
- R6: When several enabled entries match, the entry with the highest index decides both the translation and the permission.
- R7: Permission bit 0 enables read, bit 1 enables write and bit 2 enables execute. `req_type` 2'b00 is a read, 2'b01 a write, 2'b10 an execute, and 2'b11 is always denied.
- R8: A denied request never asserts `mem_valid`.
- R9: When a denial occurs with no fault held, `flt_addr` captures the logical address. `flt_stat` captures {no-match, req_type}, where bit 2 is 1 only when no enabled entry matched.
- R10: A held fault is not overwritten by later denials. A `flt_clr` pulse empties the fault registers. If a denial arrives in the same cycle as `flt_clr`, that denial is captured instead.
- R11: A `cfg_we` pulse writes every field of entry `cfg_idx`, and the new entry applies to a request sampled at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for one segment entry |
| cfg_idx | input | 4 | Index of the entry to write |
| cfg_lbase | input | 32 | Logical base to write |
| cfg_pbase | input | 36 | Physical base to write |
| cfg_size | input | 5 | Size code to write (0 disables the entry) |
| cfg_perm | input | 3 | Permissions to write: {exec, write, read} |
| req_valid | input | 1 | Request present |
| req_type | input | 2 | 00 read, 01 write, 10 execute, 11 invalid |
| req_addr | input | 32 | Logical address |
| mem_valid | output | 1 | Granted request forwarded to memory |
| mem_addr | output | 36 | Translated physical address |
| mem_type | output | 2 | Access type of the forwarded request |
| deny | output | 1 | One-cycle pulse for a blocked request |
| flt_clr | input | 1 | Clears the held fault |
| flt_valid | output | 1 | A fault is held |
| flt_addr | output | 32 | Logical address of the held fault |
| flt_stat | output | 3 | {no-match, access type} of the held fault |

## Verification
The assertions check the cycle-level properties on every clock. Each request yields exactly one outcome, a grant and a deny never coincide, and the low address bits pass through unchanged. A held fault stays stable, a clear with no request empties it, a captured fault names the address of the previous request, and the invalid type is always denied. Only the bench scenarios can show that translation is correct, that the highest index wins, that an unaligned base covers the aligned-down block, that disabled and oversize codes behave as specified, and that a table write takes effect on the next request.

// File: rtl/seg_pkg.sv
package seg_pkg;
  typedef enum logic [1:0] {
    ACC_RD  = 2'b00,
    ACC_WR  = 2'b01,
    ACC_EX  = 2'b10,
    ACC_BAD = 2'b11
  } acc_e;

  localparam int PERM_W  = 3;
  localparam int PERM_RD = 0;
  localparam int PERM_WR = 1;
  localparam int PERM_EX = 2;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile #(
  parameter int NSEG = 16,
  parameter int LAW  = 32,
  parameter int PAW  = 36,
  parameter int SZW  = 5,
  localparam int IW  = $clog2(NSEG)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [IW-1:0]                 idx,
  input  logic [LAW-1:0]                lbase_in,
  input  logic [PAW-1:0]                pbase_in,
  input  logic [SZW-1:0]                size_in,
  input  logic [seg_pkg::PERM_W-1:0]    perm_in,
  output logic [NSEG-1:0][LAW-1:0]      lbase,
  output logic [NSEG-1:0][PAW-1:0]      pbase,
  output logic [NSEG-1:0][SZW-1:0]      size,
  output logic [NSEG-1:0][seg_pkg::PERM_W-1:0] perm
);
  // The table is kept in flops because every entry is compared in parallel.
  for (genvar i = 0; i < NSEG; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        lbase[i] <= '0;
        pbase[i] <= '0;
        size[i]  <= '0;
        perm[i]  <= '0;
      end else if (we && (idx == IW'(i))) begin
        lbase[i] <= lbase_in;
        pbase[i] <= pbase_in;
        size[i]  <= size_in;
        perm[i]  <= perm_in;
      end
    end
  end
endmodule

// File: rtl/seg_match.sv
module seg_match #(
  parameter int NSEG   = 16,
  parameter int LAW    = 32,
  parameter int PAW    = 36,
  parameter int SZW    = 5,
  parameter int MIN_SH = 12
) (
  input  logic [LAW-1:0]                addr,
  input  logic [1:0]                    typ,
  input  logic [NSEG-1:0][LAW-1:0]      lbase,
  input  logic [NSEG-1:0][PAW-1:0]      pbase,
  input  logic [NSEG-1:0][SZW-1:0]      size,
  input  logic [NSEG-1:0][seg_pkg::PERM_W-1:0] perm,
  output logic                          any_hit,
  output logic                          allow,
  output logic [PAW-1:0]                phys
);
  import seg_pkg::*;

  localparam int SHW  = $clog2(LAW + 1);
  localparam int MAXC = LAW - MIN_SH + 1;
  localparam int XW   = PAW - LAW;

  logic [NSEG-1:0]           hit;
  logic [NSEG-1:0]           pok;
  logic [NSEG-1:0][PAW-1:0]  pcand;

  for (genvar i = 0; i < NSEG; i++) begin : g_cmp
    logic [SHW-1:0] sh;
    logic [LAW-1:0] hmask;

    always_comb begin
      if (size[i] >= SZW'(MAXC)) sh = SHW'(LAW);
      else                       sh = SHW'(size[i]) + SHW'(MIN_SH - 1);
      hmask    = {LAW{1'b1}} << sh;
      hit[i]   = (size[i] != '0) && (((addr ^ lbase[i]) & hmask) == '0);
      pcand[i] = (pbase[i] & {{XW{1'b1}}, hmask}) | {{XW{1'b0}}, addr & ~hmask};
      unique case (acc_e'(typ))
        ACC_RD:  pok[i] = perm[i][PERM_RD];
        ACC_WR:  pok[i] = perm[i][PERM_WR];
        ACC_EX:  pok[i] = perm[i][PERM_EX];
        default: pok[i] = 1'b0;
      endcase
    end
  end

  // A later index overrides an earlier one, so the highest index wins.
  always_comb begin
    any_hit = 1'b0;
    allow   = 1'b0;
    phys    = '0;
    for (int i = 0; i < NSEG; i++) begin
      if (hit[i]) begin
        any_hit = 1'b1;
        allow   = pok[i];
        phys    = pcand[i];
      end
    end
  end
endmodule

// File: rtl/seg_fault.sv
module seg_fault #(
  parameter int LAW = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           deny_now,
  input  logic           nomatch,
  input  logic [1:0]     typ,
  input  logic [LAW-1:0] addr,
  input  logic           clr,
  output logic           flt_valid,
  output logic [LAW-1:0] flt_addr,
  output logic [2:0]     flt_stat
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flt_valid <= 1'b0;
      flt_addr  <= '0;
      flt_stat  <= '0;
    end else if (deny_now && (!flt_valid || clr)) begin
      flt_valid <= 1'b1;
      flt_addr  <= addr;
      flt_stat  <= {nomatch, typ};
    end else if (clr) begin
      flt_valid <= 1'b0;
      flt_addr  <= '0;
      flt_stat  <= '0;
    end
  end
endmodule

// File: rtl/seg_xlate_prot.sv
module seg_xlate_prot #(
  parameter int NSEG   = 16,
  parameter int LAW    = 32,
  parameter int PAW    = 36,
  parameter int SZW    = 5,
  parameter int MIN_SH = 12,
  localparam int IW    = $clog2(NSEG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [IW-1:0]   cfg_idx,
  input  logic [LAW-1:0]  cfg_lbase,
  input  logic [PAW-1:0]  cfg_pbase,
  input  logic [SZW-1:0]  cfg_size,
  input  logic [2:0]      cfg_perm,
  input  logic            req_valid,
  input  logic [1:0]      req_type,
  input  logic [LAW-1:0]  req_addr,
  output logic            mem_valid,
  output logic [PAW-1:0]  mem_addr,
  output logic [1:0]      mem_type,
  output logic            deny,
  input  logic            flt_clr,
  output logic            flt_valid,
  output logic [LAW-1:0]  flt_addr,
  output logic [2:0]      flt_stat
);
  logic [NSEG-1:0][LAW-1:0] t_lbase;
  logic [NSEG-1:0][PAW-1:0] t_pbase;
  logic [NSEG-1:0][SZW-1:0] t_size;
  logic [NSEG-1:0][2:0]     t_perm;
  logic                     any_hit;
  logic                     allow;
  logic [PAW-1:0]           phys;
  logic                     deny_now;

  seg_regfile #(.NSEG(NSEG), .LAW(LAW), .PAW(PAW), .SZW(SZW)) u_tab (
    .clk(clk), .rst(rst), .we(cfg_we), .idx(cfg_idx),
    .lbase_in(cfg_lbase), .pbase_in(cfg_pbase), .size_in(cfg_size), .perm_in(cfg_perm),
    .lbase(t_lbase), .pbase(t_pbase), .size(t_size), .perm(t_perm)
  );

  seg_match #(.NSEG(NSEG), .LAW(LAW), .PAW(PAW), .SZW(SZW), .MIN_SH(MIN_SH)) u_match (
    .addr(req_addr), .typ(req_type),
    .lbase(t_lbase), .pbase(t_pbase), .size(t_size), .perm(t_perm),
    .any_hit(any_hit), .allow(allow), .phys(phys)
  );

  assign deny_now = req_valid && !(any_hit && allow);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_type  <= '0;
      deny      <= 1'b0;
    end else begin
      mem_valid <= req_valid && any_hit && allow;
      deny      <= deny_now;
      mem_type  <= req_type;
      mem_addr  <= (any_hit && allow) ? phys : '0;
    end
  end

  seg_fault #(.LAW(LAW)) u_flt (
    .clk(clk), .rst(rst), .deny_now(deny_now), .nomatch(!any_hit),
    .typ(req_type), .addr(req_addr), .clr(flt_clr),
    .flt_valid(flt_valid), .flt_addr(flt_addr), .flt_stat(flt_stat)
  );
endmodule

// File: rtl/seg_xlate_prot_chk.sv
module seg_xlate_prot_chk #(
  parameter int LAW    = 32,
  parameter int MIN_SH = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [1:0]        req_type,
  input logic [LAW-1:0]    req_addr,
  input logic              mem_valid,
  input logic [MIN_SH-1:0] mem_lo,
  input logic              deny,
  input logic              flt_clr,
  input logic              flt_valid,
  input logic [LAW-1:0]    flt_addr,
  input logic [2:0]        flt_stat
);
  p_one_outcome_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (mem_valid || deny));
  p_no_outcome_r2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !(mem_valid || deny));
  p_block_r8: assert property (@(posedge clk) disable iff (rst)
    !(mem_valid && deny));
  p_lowbits_r3: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (!mem_valid || mem_lo == $past(req_addr[MIN_SH-1:0])));
  p_badtype_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_type == 2'b11) |=> deny);
  p_capture_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(flt_valid) |-> (deny && flt_addr == $past(req_addr)));
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (flt_valid && !flt_clr) |=> (flt_valid && $stable(flt_addr) && $stable(flt_stat)));
  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (flt_clr && !req_valid) |=> !flt_valid);
endmodule

bind seg_xlate_prot seg_xlate_prot_chk #(.LAW(LAW), .MIN_SH(MIN_SH)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_type(req_type), .req_addr(req_addr),
  .mem_valid(mem_valid), .mem_lo(mem_addr[MIN_SH-1:0]), .deny(deny), .flt_clr(flt_clr),
  .flt_valid(flt_valid), .flt_addr(flt_addr), .flt_stat(flt_stat)
);

// File: tb/sim_seg_xlate_prot.sv
`timescale 1ns/1ps
module sim_seg_xlate_prot;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [31:0] cfg_lbase = '0;
  logic [35:0] cfg_pbase = '0;
  logic [4:0]  cfg_size = '0;
  logic [2:0]  cfg_perm = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_type = '0;
  logic [31:0] req_addr = '0;
  logic        flt_clr = 1'b0;
  logic        mem_valid, deny, flt_valid;
  logic [35:0] mem_addr;
  logic [1:0]  mem_type;
  logic [31:0] flt_addr;
  logic [2:0]  flt_stat;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  seg_xlate_prot u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_lbase(cfg_lbase),
    .cfg_pbase(cfg_pbase), .cfg_size(cfg_size), .cfg_perm(cfg_perm),
    .req_valid(req_valid), .req_type(req_type), .req_addr(req_addr),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_type(mem_type), .deny(deny),
    .flt_clr(flt_clr), .flt_valid(flt_valid), .flt_addr(flt_addr), .flt_stat(flt_stat)
  );

  typedef struct packed {
    logic [1:0]  typ;
    logic [31:0] addr;
    logic        ok;
    logic [35:0] pa;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 32'h6010_1234, 1'b1, 36'h8_6010_1234, 8'd3},  // R3 entry 0
    '{2'b01, 32'h603F_FFFC, 1'b1, 36'h8_603F_FFFC, 8'd7},  // R7 write allowed
    '{2'b10, 32'h6010_0000, 1'b0, 36'h0,           8'd7},  // R7 exec not allowed
    '{2'b00, 32'h6041_0008, 1'b1, 36'h1_2341_0008, 8'd3},  // 2 MB entry 1
    '{2'b01, 32'h6041_0008, 1'b0, 36'h0,           8'd7},  // read-only entry
    '{2'b10, 32'h6000_1000, 1'b1, 36'h0_0005_1000, 8'd6},  // R6 entry 2 over 0
    '{2'b00, 32'h6000_1000, 1'b0, 36'h0,           8'd6},  // entry 2 denies read
    '{2'b00, 32'h6000_8ABC, 1'b1, 36'hF_FFFF_FABC, 8'd6},  // entry 15 wins
    '{2'b00, 32'h6250_0010, 1'b1, 36'h3_0050_0010, 8'd5},  // R5 aligned-down
    '{2'b01, 32'h6290_0000, 1'b0, 36'h0,           8'd5},  // past aligned block
    '{2'b00, 32'h7000_0000, 1'b0, 36'h0,           8'd4},  // R4 disabled entry
    '{2'b11, 32'h6010_0000, 1'b0, 36'h0,           8'd7},  // invalid type
    '{2'b00, 32'h605F_FFFF, 1'b1, 36'h1_235F_FFFF, 8'd4},  // last byte of 2 MB
    '{2'b00, 32'h6060_0000, 1'b0, 36'h0,           8'd4}   // first byte after
  };

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr_ent(input int i, input logic [31:0] lb, input logic [35:0] pb,
                        input logic [4:0] sz, input logic [2:0] pm);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'(i); cfg_lbase = lb; cfg_pbase = pb;
    cfg_size = sz; cfg_perm = pm;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Presents one request for one cycle; outputs are valid at the following negedge.
  task automatic do_req(input logic [1:0] t, input logic [31:0] a, input logic clr);
    @(negedge clk);
    req_valid = 1'b1; req_type = t; req_addr = a; flt_clr = clr;
    @(negedge clk);
    req_valid = 1'b0; flt_clr = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    flt_clr = 1'b1;
    @(negedge clk);
    flt_clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 mem_valid after reset", 64'(mem_valid), 64'd0);
    check("R1 deny after reset",      64'(deny),      64'd0);
    check("R1 flt_valid after reset", 64'(flt_valid), 64'd0);
    do_req(2'b00, 32'h6010_0000, 1'b0);
    check("R1 empty table denies (no-match)", 64'(flt_stat), 64'b100);
    pulse_clr();

    wr_ent(0,  32'h6000_0000, 36'h8_6000_0000, 5'd11, 3'b011);
    wr_ent(1,  32'h6040_0000, 36'h1_2340_0000, 5'd10, 3'b001);
    wr_ent(2,  32'h6000_0000, 36'h0_0005_0000, 5'd5,  3'b100);
    wr_ent(3,  32'h6260_0000, 36'h3_0060_0000, 5'd11, 3'b111);
    wr_ent(4,  32'h7000_0000, 36'h7_0000_0000, 5'd0,  3'b111);
    wr_ent(15, 32'h6000_8000, 36'hF_FFFF_F000, 5'd1,  3'b011);

    for (int v = 0; v < NV; v++) begin
      do_req(VECS[v].typ, VECS[v].addr, 1'b0);
      check($sformatf("R2 R%0d vec %0d mem_valid", VECS[v].rq, v), 64'(mem_valid), 64'(VECS[v].ok));
      check($sformatf("R8 R%0d vec %0d deny", VECS[v].rq, v), 64'(deny), 64'(!VECS[v].ok));
      if (VECS[v].ok) begin
        check($sformatf("R3 R%0d vec %0d mem_addr", VECS[v].rq, v), 64'(mem_addr), 64'(VECS[v].pa));
        check($sformatf("R3 vec %0d mem_type", v), 64'(mem_type), 64'(VECS[v].typ));
      end
    end

    // The first denial in the walk (vector 2, exec at 0x6010_0000) must still be held.
    check("R10 held address", 64'(flt_addr), 64'h6010_0000);
    check("R9 held status permission/exec", 64'(flt_stat), 64'b010);
    check("R10 held valid", 64'(flt_valid), 64'd1);

    pulse_clr();
    check("R10 clear empties", 64'(flt_valid), 64'd0);
    do_req(2'b00, 32'h7000_0000, 1'b0);
    check("R9 no-match address", 64'(flt_addr), 64'h7000_0000);
    check("R9 no-match status", 64'(flt_stat), 64'b100);
    do_req(2'b01, 32'h6290_0000, 1'b1);
    check("R10 clear with denial captures new address", 64'(flt_addr), 64'h6290_0000);
    check("R10 clear with denial captures new status", 64'(flt_stat), 64'b101);
    pulse_clr();

    // R11 and R4: oversize code, request presented in the cycle after the write.
    do_req(2'b00, 32'h9000_0000, 1'b0);
    check("R11 before write denied", 64'(deny), 64'd1);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'd14; cfg_lbase = 32'h1234_5678;
    cfg_pbase = 36'hA_1234_5678; cfg_size = 5'd31; cfg_perm = 3'b001;
    @(negedge clk);
    cfg_we = 1'b0;
    req_valid = 1'b1; req_type = 2'b00; req_addr = 32'h9000_0000;
    @(negedge clk);
    req_valid = 1'b0;
    check("R11 write applies next cycle", 64'(mem_valid), 64'd1);
    check("R4 oversize code covers 4 GB", 64'(mem_addr), 64'hA_9000_0000);

    // R1 reset clears the table.
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    do_req(2'b00, 32'h6010_1234, 1'b0);
    check("R1 table cleared by reset", 64'(deny), 64'd1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule